// File: doc/BRIEF.md
# Paged Indirect Register Bridge

This block sits on the slave side of a 16-bit management request port that names a target by PHY address and register number. It gives that port access to a flat 32-bit internal register space. One reserved location (PHY address 0x18, register 0) holds a page value. Every PHY address from 0x10 to 0x17 is a data window. Its low three bits, the upper four bits of the register number and the stored page together pick one 32-bit internal register. The register number's least significant bit picks one 16-bit half of that register.

Software moves each 32-bit value as two 16-bit accesses, always the low half first. A low-half write is held in a staging register. The single 32-bit internal write goes out when the high half arrives. A low-half read fetches the whole internal register and keeps its upper half. The high-half read that follows returns that kept value, so both halves come from one snapshot. The internal port is combinational: address, write data and write strobe follow the current request in the same cycle, and internal read data is expected back in that same cycle. Management read data is registered. It is valid from the clock edge that samples the read strobe and holds until the next read.

Top module: `paged_reg_bridge`

## Requirements
- R1: After reset the page is 0, `mg_rdata` is 0x0000, and `rg_we` stays low while no request is presented.
- R2: A write to PHY address 0x18, register 0 loads the page from `mg_wdata[9:0]`. Bits 15:10 are discarded.
- R3: A read of PHY address 0x18, register 0 returns the page zero-extended to 16 bits. The value appears on `mg_rdata` from the clock edge that samples `mg_re`.
- R4: During a data-window request (PHY address 0x10 to 0x17), `rg_addr` equals {page[9:0], phy[2:0], reg[4:1], 2'b00}.
- R5: A write to an even register in a data window only stages the 16-bit value. It does not assert `rg_we`.
- R6: A write to an odd register in a data window asserts `rg_we` for that request cycle, with `rg_wdata` = {this write's data, most recently staged low half}.
- R7: A read of an even register in a data window returns `rg_rdata[15:0]` for the addressed register, and latches `rg_rdata[31:16]`.
- R8: A read of an odd register in a data window returns the upper half latched by the last even-register read, even if the internal register has changed since.
- R9: Requests to other PHY addresses, and to PHY address 0x18 with a nonzero register, are ignored. Their writes change neither the page nor the internal space, and their reads return 0xFFFF.
- R10: `mg_rdata` keeps its value in every cycle without a read strobe, including cycles with writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mg_phy | input | 5 | Management PHY address |
| mg_reg | input | 5 | Management register number |
| mg_wdata | input | 16 | Management write data |
| mg_we | input | 1 | Management write strobe, one cycle per access |
| mg_re | input | 1 | Management read strobe, one cycle per access |
| mg_rdata | output | 16 | Registered management read data |
| rg_addr | output | 19 | Internal byte address of the 32-bit register |
| rg_wdata | output | 32 | Internal write data |
| rg_we | output | 1 | Internal write strobe |
| rg_rdata | input | 32 | Internal read data for `rg_addr`, same cycle |

## Verification
The bench sweeps every data window and every register pair under four page values. It also writes a page value with its upper bits set, so a bridge that kept more than ten page bits would send each write to the wrong address. Between the low-half and high-half reads the bench changes the internal register contents. A bridge that fetched the high half afresh, instead of returning the snapshot, would return the new upper bits. Low-half writes are checked to leave `rg_we` low, which catches a bridge that writes each half separately. Accesses to foreign PHY addresses and to other registers at the page address are checked to leave the page alone and to read back 0xFFFF. A careless decoder would let them load the page.

// File: rtl/pibr_pkg.sv
package pibr_pkg;
  // Request class produced by the address decoder
  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_PAGE = 2'd1,
    K_LO   = 2'd2,
    K_HI   = 2'd3
  } kind_e;
endpackage

// File: rtl/pibr_decode.sv
module pibr_decode
  import pibr_pkg::*;
#(
  parameter int PHY_W = 5,
  parameter int REG_W = 5,
  parameter int SEL_W = 3,
  parameter logic [PHY_W-1:0] PAGE_PHY  = 5'h18,
  parameter logic [REG_W-1:0] PAGE_REG  = '0,
  parameter logic [PHY_W-1:0] DATA_BASE = 5'h10
) (
  input  logic [PHY_W-1:0] phy,
  input  logic [REG_W-1:0] regn,
  output kind_e            kind,
  output logic [SEL_W-1:0] sel
);
  localparam int TAG_W = PHY_W - SEL_W;
  localparam logic [TAG_W-1:0] DATA_TAG = DATA_BASE[PHY_W-1:SEL_W];

  logic data_hit;

  assign data_hit = (phy[PHY_W-1:SEL_W] == DATA_TAG);
  assign sel      = phy[SEL_W-1:0];

  always_comb begin
    kind = K_NONE;
    if (phy == PAGE_PHY) begin
      if (regn == PAGE_REG) kind = K_PAGE;
    end else if (data_hit) begin
      kind = regn[0] ? K_HI : K_LO;
    end
  end
endmodule

// File: rtl/pibr_page.sv
module pibr_page #(
  parameter int PAGE_W = 10,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [HALF_W-1:0] wdata,
  output logic [PAGE_W-1:0] page
);
  always_ff @(posedge clk) begin
    if (rst)        page <= '0;
    else if (wr_en) page <= wdata[PAGE_W-1:0];
  end

  // R1
  page_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> page == '0);

  // R9
  page_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> $stable(page));
endmodule

// File: rtl/pibr_join.sv
module pibr_join #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lo_wr,
  input  logic                hi_wr,
  input  logic [HALF_W-1:0]   wdata,
  input  logic                lo_rd,
  input  logic                hi_rd,
  input  logic                pg_rd,
  input  logic                bad_rd,
  input  logic [HALF_W-1:0]   page_val,
  input  logic [2*HALF_W-1:0] int_rdata,
  output logic                int_we,
  output logic [2*HALF_W-1:0] int_wdata,
  output logic [HALF_W-1:0]   rdata
);
  logic [HALF_W-1:0] stage_q;
  logic [HALF_W-1:0] snap_q;
  logic              any_rd;

  assign any_rd    = lo_rd | hi_rd | pg_rd | bad_rd;
  assign int_we    = hi_wr;
  assign int_wdata = {wdata, stage_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (lo_wr) begin
      stage_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      rdata  <= '0;
    end else begin
      if (lo_rd) begin
        rdata  <= int_rdata[HALF_W-1:0];
        snap_q <= int_rdata[2*HALF_W-1:HALF_W];
      end else if (hi_rd) begin
        rdata <= snap_q;
      end else if (pg_rd) begin
        rdata <= page_val;
      end else if (bad_rd) begin
        rdata <= '1;
      end
    end
  end

  // R5
  lo_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    lo_wr |-> !int_we);

  // R8
  hi_snapshot_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lo_rd) && hi_rd) |-> ##1 rdata == $past(int_rdata[2*HALF_W-1:HALF_W], 2));

  // R9
  bad_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bad_rd)) |-> rdata == '1);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(any_rd)) |-> $stable(rdata));
endmodule

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge
  import pibr_pkg::*;
#(
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int SEL_W  = 3,
  parameter int PAGE_W = 10,
  parameter int HALF_W = 16,
  parameter logic [PHY_W-1:0] PAGE_PHY  = 5'h18,
  parameter logic [PHY_W-1:0] DATA_BASE = 5'h10,
  localparam int WORD_W = 2 * HALF_W,
  localparam int OFS_W  = $clog2(WORD_W / 8),
  localparam int ADDR_W = PAGE_W + SEL_W + (REG_W - 1) + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHY_W-1:0]  mg_phy,
  input  logic [REG_W-1:0]  mg_reg,
  input  logic [HALF_W-1:0] mg_wdata,
  input  logic              mg_we,
  input  logic              mg_re,
  output logic [HALF_W-1:0] mg_rdata,
  output logic [ADDR_W-1:0] rg_addr,
  output logic [WORD_W-1:0] rg_wdata,
  output logic              rg_we,
  input  logic [WORD_W-1:0] rg_rdata
);
  kind_e             kind;
  logic [SEL_W-1:0]  sel;
  logic [PAGE_W-1:0] page;
  logic [HALF_W-1:0] page_val;

  pibr_decode #(
    .PHY_W(PHY_W), .REG_W(REG_W), .SEL_W(SEL_W),
    .PAGE_PHY(PAGE_PHY), .PAGE_REG('0), .DATA_BASE(DATA_BASE)
  ) u_dec (
    .phy(mg_phy), .regn(mg_reg), .kind(kind), .sel(sel)
  );

  pibr_page #(.PAGE_W(PAGE_W), .HALF_W(HALF_W)) u_page (
    .clk(clk), .rst(rst),
    .wr_en(mg_we && kind == K_PAGE),
    .wdata(mg_wdata), .page(page)
  );

  assign page_val = {{(HALF_W-PAGE_W){1'b0}}, page};
  assign rg_addr  = {page, sel, mg_reg[REG_W-1:1], {OFS_W{1'b0}}};

  pibr_join #(.HALF_W(HALF_W)) u_join (
    .clk(clk), .rst(rst),
    .lo_wr(mg_we && kind == K_LO),
    .hi_wr(mg_we && kind == K_HI),
    .wdata(mg_wdata),
    .lo_rd(mg_re && kind == K_LO),
    .hi_rd(mg_re && kind == K_HI),
    .pg_rd(mg_re && kind == K_PAGE),
    .bad_rd(mg_re && kind == K_NONE),
    .page_val(page_val),
    .int_rdata(rg_rdata),
    .int_we(rg_we),
    .int_wdata(rg_wdata),
    .rdata(mg_rdata)
  );

  // R6
  hi_write_chk: assert property (@(posedge clk) disable iff (rst)
    rg_we |-> (mg_we && mg_reg[0] && mg_phy != PAGE_PHY));

  // R3
  page_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mg_re) && $past(mg_phy) == PAGE_PHY && $past(mg_reg) == '0)
      |-> mg_rdata == {{(HALF_W-PAGE_W){1'b0}}, $past(page)});
endmodule

// File: tb/sim_paged_reg_bridge.sv
module sim_paged_reg_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  mg_phy = '0;
  logic [4:0]  mg_reg = '0;
  logic [15:0] mg_wdata = '0;
  logic        mg_we = 1'b0;
  logic        mg_re = 1'b0;
  logic [15:0] mg_rdata;
  logic [18:0] rg_addr;
  logic [31:0] rg_wdata;
  logic        rg_we;
  logic [31:0] rg_rdata;
  logic [15:0] epoch = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  // Internal register space modelled arithmetically
  function automatic logic [31:0] model(input logic [18:0] a, input logic [15:0] ep);
    return (32'(a) * 32'h9E3779B1) ^ {ep, 16'h0000};
  endfunction
  assign rg_rdata = model(rg_addr, epoch);

  paged_reg_bridge u0 (
    .clk(clk), .rst(rst), .mg_phy(mg_phy), .mg_reg(mg_reg),
    .mg_wdata(mg_wdata), .mg_we(mg_we), .mg_re(mg_re), .mg_rdata(mg_rdata),
    .rg_addr(rg_addr), .rg_wdata(rg_wdata), .rg_we(rg_we), .rg_rdata(rg_rdata)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic        seen_we;
  logic [18:0] seen_addr;
  logic [31:0] seen_wdata;

  task automatic wr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    mg_phy = p; mg_reg = r; mg_wdata = d; mg_we = 1'b1;
    #1;
    seen_we = rg_we; seen_addr = rg_addr; seen_wdata = rg_wdata;
    @(posedge clk); #1;
    mg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] p, input logic [4:0] r, output logic [15:0] d);
    @(negedge clk);
    mg_phy = p; mg_reg = r; mg_re = 1'b1;
    #1;
    seen_addr = rg_addr;
    @(posedge clk); #1;
    d = mg_rdata;
    mg_re = 1'b0;
  endtask

  initial begin : watchdog
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [15:0] d, hold;
    logic [15:0] pvals [5];
    logic [31:0] exp_word;
    pvals[0] = 16'h0000; pvals[1] = 16'h0001; pvals[2] = 16'h02AB;
    pvals[3] = 16'h03FF; pvals[4] = 16'hFC05;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    // R1 reset state
    check(mg_rdata == 16'h0000, "R1 rdata after reset", 32'(mg_rdata), 0);
    check(rg_we == 1'b0, "R1 no internal write", 32'(rg_we), 0);
    rd(5'h18, 5'd0, d);
    check(d == 16'h0000, "R1 page after reset", 32'(d), 0);

    for (int pi = 0; pi < 5; pi++) begin
      logic [9:0] pg;
      pg = pvals[pi][9:0];
      wr(5'h18, 5'd0, pvals[pi]);
      check(seen_we == 1'b0, "R2 page write no internal write", 32'(seen_we), 0);
      rd(5'h18, 5'd0, d);
      check(d == 16'(pg), "R2 R3 page readback", 32'(d), 32'(pg));
      for (int r2 = 0; r2 < 8; r2++) begin
        for (int k = 0; k < 16; k++) begin
          logic [15:0] lo, hi;
          logic [18:0] ea;
          ea = 19'(32'(pg) * 512 + r2 * 64 + k * 4);
          lo = 16'(pi * 4099 + r2 * 257 + k * 17 + 3);
          hi = 16'(pi * 811 + r2 * 53 + k * 1001 + 9);
          wr(5'(16 + r2), 5'(2 * k), lo);
          check(seen_we == 1'b0, "R5 low half staged only", 32'(seen_we), 0);
          wr(5'(16 + r2), 5'(2 * k + 1), hi);
          check(seen_we == 1'b1, "R6 high half writes", 32'(seen_we), 1);
          check(seen_addr == ea, "R4 write address", 32'(seen_addr), 32'(ea));
          check(seen_wdata == {hi, lo}, "R6 joined write data", seen_wdata, {hi, lo});
          exp_word = model(ea, epoch);
          rd(5'(16 + r2), 5'(2 * k), d);
          check(seen_addr == ea, "R4 read address", 32'(seen_addr), 32'(ea));
          check(d == exp_word[15:0], "R7 low half read", 32'(d), 32'(exp_word[15:0]));
          epoch = epoch + 16'h1357;
          rd(5'(16 + r2), 5'(2 * k + 1), d);
          check(d == exp_word[31:16], "R8 high half snapshot", 32'(d), 32'(exp_word[31:16]));
        end
      end
    end

    // R10 hold across idle cycles and writes
    hold = mg_rdata;
    repeat (4) @(posedge clk);
    #1 check(mg_rdata == hold, "R10 hold when idle", 32'(mg_rdata), 32'(hold));
    wr(5'h11, 5'd4, 16'hBEEF);
    wr(5'h18, 5'd0, 16'h0123);
    check(mg_rdata == hold, "R10 hold across writes", 32'(mg_rdata), 32'(hold));

    // R9 ignored accesses
    wr(5'h05, 5'd0, 16'h0077);
    check(seen_we == 1'b0, "R9 foreign write no internal write", 32'(seen_we), 0);
    wr(5'h08, 5'd1, 16'h0077);
    check(seen_we == 1'b0, "R9 foreign odd write no internal write", 32'(seen_we), 0);
    wr(5'h18, 5'd3, 16'h0055);
    check(seen_we == 1'b0, "R9 page-address other reg no internal write", 32'(seen_we), 0);
    wr(5'h19, 5'd0, 16'h0066);
    rd(5'h18, 5'd0, d);
    check(d == 16'h0123, "R9 page unchanged by ignored writes", 32'(d), 32'h0123);
    rd(5'h1F, 5'd0, d);
    check(d == 16'hFFFF, "R9 foreign read", 32'(d), 32'hFFFF);
    rd(5'h0F, 5'd7, d);
    check(d == 16'hFFFF, "R9 foreign read below window", 32'(d), 32'hFFFF);
    rd(5'h18, 5'd2, d);
    check(d == 16'hFFFF, "R9 page-address other reg read", 32'(d), 32'hFFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule